// File: doc/BRIEF.md
# Physical Region Descriptor Table Builder

This block converts a list of scatter segments (a 32-bit bus address and a byte length) into the two-word descriptors that a bus-master disk DMA engine reads from memory. Each descriptor holds a base-address word and then a control word. The control word carries the byte count and the end-of-table flag. The block cuts every segment into pieces so that no piece crosses a 64 KB address boundary. It limits the table to a fixed number of descriptors, flags the final one, and reports an error code so that the caller can fall back to programmed I/O for the request.

Segments arrive on a valid/ready input stream, and a segment of length zero closes the list. Descriptor words leave on a valid/ready output stream: the address word first, then the control word. Both streams follow the same rule. A word or segment transfers on a rising edge where valid and ready are both high. Once the block raises `wr_valid`, it holds `wr_data` and `wr_last` unchanged until `wr_ready` is high. The block lowers `seg_ready` while it is still cutting the current segment.

Two static configuration pins change the encoding. The first splits a full 64 KB piece into two 32 KB descriptors, for controllers that misread a zero count. The second selects a dword-based count in the upper half-word. When the table is finished or aborted, `done` pulses for one cycle, and `err_code` and `entry_count` are valid in that cycle.

Top module: `prdgen_top`

## Requirements
- R1: Each descriptor covers min(0x10000 − address[15:0], remaining segment bytes), starting at the segment address and advancing in address order. No descriptor crosses a 64 KB boundary.
- R2: In the default encoding, control bits [15:0] hold the byte count modulo 65536, so a full 64 KB piece encodes as 0x0000. Bits [30:16] are zero.
- R3: With `cfg_split_64k` high and the default encoding, a full 64 KB piece at address A becomes two descriptors, (A, 0x8000) then (A+0x8000, 0x8000), and uses two table slots.
- R4: With `cfg_wide_count` high, control bits [29:16] hold (bytes/4 − 1), bits [15:0] and bit 30 are zero, and `cfg_split_64k` has no effect.
- R5: A non-zero segment must be even in address and length (default encoding) or a multiple of 4 in both (wide encoding). Otherwise the table aborts with `err_code` = 3.
- R6: If a piece needs more slots than remain of MAX_ENTRIES, the table aborts with `err_code` = 1. `entry_count` then gives the descriptors admitted before the abort. A table that fills exactly MAX_ENTRIES slots succeeds.
- R7: On success, bit 31 of the final control word is set and `wr_last` is high with that word only. No other control word has bit 31 set.
- R8: A list whose first segment has length zero ends with `err_code` = 2, `entry_count` = 0 and no words written.
- R9: `done` is a one-cycle pulse, raised only after every word of the table has transferred. On success `err_code` = 0 and `entry_count` equals the number of descriptors written.
- R10: Words appear address first, then control. Under back-pressure `wr_valid`, `wr_data` and `wr_last` hold steady.
- R11: A zero-length segment ends the list. The next segment starts a new table.
- R12: After reset `wr_valid` = 0, `done` = 0 and `seg_ready` = 1.
- R13: On any abort, the descriptor that was held back for end-marking is never written. Every descriptor before it is written unmarked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_split_64k | input | 1 | Emit full 64 KB pieces as two halves (default encoding only) |
| cfg_wide_count | input | 1 | Select the dword count in the upper half-word |
| seg_valid | input | 1 | Segment offered |
| seg_ready | output | 1 | Segment accepted when high with seg_valid |
| seg_addr | input | 32 | Segment bus address |
| seg_len | input | LEN_W | Segment length in bytes; zero ends the list |
| wr_valid | output | 1 | Descriptor word offered |
| wr_ready | input | 1 | Sink accepts the word |
| wr_data | output | 32 | Address word or control word |
| wr_last | output | 1 | Final word of a successful table |
| done | output | 1 | One-cycle end-of-table pulse |
| err_code | output | 2 | 0 ok, 1 table full, 2 empty, 3 misaligned |
| entry_count | output | $clog2(MAX_ENTRIES+1) | Descriptors admitted to the table |

## Verification
The hardest case to reach is a split 64 KB piece arriving when exactly one slot is left. The block must then abort without writing either half and without losing the descriptors before it. A directed table fills all but one slot with small pieces and then offers an aligned 64 KB segment in split mode. Seeded random tables mix segment lengths, misalignment and back-pressure around a reduced table capacity, so that aborts and exactly-full tables occur often.

// File: rtl/prdgen_pkg.sv
package prdgen_pkg;

  typedef enum logic [1:0] {
    PRD_OK        = 2'd0,
    PRD_ERR_FULL  = 2'd1,
    PRD_ERR_EMPTY = 2'd2,
    PRD_ERR_ALIGN = 2'd3
  } prd_err_e;

  typedef struct packed {
    logic [31:0] base;
    logic [31:0] ctrl;
  } prd_entry_t;

  localparam logic [31:0] HALF_CTRL   = 32'h0000_8000;
  localparam logic [31:0] HALF_OFFSET = 32'h0000_8000;
  localparam logic [16:0] WINDOW      = 17'h1_0000;

endpackage

// File: rtl/prdgen_chunker.sv
// Combinational piece sizing and control-word encoding for one step.
module prdgen_chunker #(
  parameter int LEN_W = 20
) (
  input  logic [15:0]      addr_lo,
  input  logic [LEN_W-1:0] remain,
  input  logic             split_en,
  input  logic             wide_cnt,
  output logic [16:0]      chunk,
  output logic [31:0]      ctrl,
  output logic             split,
  output logic             last_piece
);
  import prdgen_pkg::*;

  logic [16:0] room;
  logic [14:0] dwords_m1;

  always_comb begin
    room = WINDOW - {1'b0, addr_lo};
    if (remain < LEN_W'(room)) chunk = remain[16:0];
    else                       chunk = room;
    last_piece = (remain == LEN_W'(chunk));
    split      = split_en & ~wide_cnt & chunk[16];
    dwords_m1  = chunk[16:2] - 15'd1;
    if (wide_cnt) ctrl = {1'b0, dwords_m1, 16'h0000};
    else          ctrl = {16'h0000, chunk[15:0]};
  end

endmodule

// File: rtl/prdgen_stage.sv
// One-entry hold-back (so the final entry can be marked) feeding a
// two-word serializer on the output stream.
module prdgen_stage (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   push_valid,
  input  prdgen_pkg::prd_entry_t push_entry,
  output logic                   push_ready,
  input  logic                   seal_valid,
  output logic                   seal_ready,
  input  logic                   discard,
  output logic                   idle,
  output logic                   wr_valid,
  input  logic                   wr_ready,
  output logic [31:0]            wr_data,
  output logic                   wr_last
);
  import prdgen_pkg::*;

  logic       hold_v;
  prd_entry_t hold_q;
  logic       ser_v;
  logic       ser_hi;
  logic       ser_last;
  prd_entry_t ser_q;

  assign push_ready = ~hold_v | ~ser_v;
  assign seal_ready = ~ser_v;
  assign idle       = ~hold_v & ~ser_v;
  assign wr_valid   = ser_v;
  assign wr_data    = ser_hi ? (ser_q.ctrl | {ser_last, 31'd0}) : ser_q.base;
  assign wr_last    = ser_v & ser_hi & ser_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_v   <= 1'b0;
      hold_q   <= '0;
      ser_v    <= 1'b0;
      ser_hi   <= 1'b0;
      ser_last <= 1'b0;
      ser_q    <= '0;
    end else begin
      if (ser_v && wr_ready) begin
        if (ser_hi) begin
          ser_v  <= 1'b0;
          ser_hi <= 1'b0;
        end else begin
          ser_hi <= 1'b1;
        end
      end
      if (discard) begin
        hold_v <= 1'b0;
      end else if (push_valid && push_ready) begin
        if (hold_v) begin
          ser_v    <= 1'b1;
          ser_hi   <= 1'b0;
          ser_last <= 1'b0;
          ser_q    <= hold_q;
        end
        hold_v <= 1'b1;
        hold_q <= push_entry;
      end else if (seal_valid && seal_ready && hold_v) begin
        ser_v    <= 1'b1;
        ser_hi   <= 1'b0;
        ser_last <= 1'b1;
        ser_q    <= hold_q;
        hold_v   <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/prdgen_seq.sv
// Segment intake, piece walk, slot accounting and table completion.
module prdgen_seq #(
  parameter int MAX_ENTRIES = 256,
  parameter int LEN_W       = 20,
  parameter int CNT_W       = $clog2(MAX_ENTRIES + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_split_64k,
  input  logic                   cfg_wide_count,
  input  logic                   seg_valid,
  output logic                   seg_ready,
  input  logic [31:0]            seg_addr,
  input  logic [LEN_W-1:0]       seg_len,
  output logic                   push_valid,
  output prdgen_pkg::prd_entry_t push_entry,
  input  logic                   push_ready,
  output logic                   seal_valid,
  input  logic                   seal_ready,
  output logic                   discard,
  input  logic                   stage_idle,
  output logic                   done,
  output logic [1:0]             err_code,
  output logic [CNT_W-1:0]       entry_count
);
  import prdgen_pkg::*;

  typedef enum logic [2:0] {
    SQ_TAKE, SQ_CHOP, SQ_HALF, SQ_SEAL, SQ_WAIT, SQ_DRAIN, SQ_FIN
  } sq_state_e;

  sq_state_e        state_q;
  logic [31:0]      cur_addr_q;
  logic [LEN_W-1:0] remain_q;
  logic [CNT_W-1:0] cnt_q;
  prd_err_e         err_q;
  logic [31:0]      half_base_q;
  logic             half_to_take_q;

  logic [16:0]      chunk;
  logic [31:0]      ctrl;
  logic             split;
  logic             last_piece;
  logic [CNT_W:0]   need_w;
  logic             over;
  logic             misalign;
  logic             seg_end;

  prdgen_chunker #(.LEN_W(LEN_W)) u_chunk (
    .addr_lo    (cur_addr_q[15:0]),
    .remain     (remain_q),
    .split_en   (cfg_split_64k),
    .wide_cnt   (cfg_wide_count),
    .chunk      (chunk),
    .ctrl       (ctrl),
    .split      (split),
    .last_piece (last_piece)
  );

  always_comb begin
    need_w   = split ? (CNT_W+1)'(2) : (CNT_W+1)'(1);
    over     = ({1'b0, cnt_q} + need_w) > (CNT_W+1)'(MAX_ENTRIES);
    misalign = cfg_wide_count ? ((seg_addr[1:0] | seg_len[1:0]) != 2'b00)
                              : (seg_addr[0] | seg_len[0]);
    seg_end  = (seg_len == '0);
  end

  always_comb begin
    seg_ready  = (state_q == SQ_TAKE) || (state_q == SQ_DRAIN);
    push_valid = 1'b0;
    push_entry = '0;
    seal_valid = 1'b0;
    discard    = 1'b0;
    case (state_q)
      SQ_TAKE: discard = seg_valid & ~seg_end & misalign;
      SQ_CHOP: begin
        if (over) begin
          discard = 1'b1;
        end else begin
          push_valid      = 1'b1;
          push_entry.base = cur_addr_q;
          push_entry.ctrl = split ? HALF_CTRL : ctrl;
        end
      end
      SQ_HALF: begin
        push_valid      = 1'b1;
        push_entry.base = half_base_q;
        push_entry.ctrl = HALF_CTRL;
      end
      SQ_SEAL: seal_valid = 1'b1;
      default: ;
    endcase
  end

  assign done        = (state_q == SQ_FIN);
  assign err_code    = err_q;
  assign entry_count = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q        <= SQ_TAKE;
      cur_addr_q     <= '0;
      remain_q       <= '0;
      cnt_q          <= '0;
      err_q          <= PRD_OK;
      half_base_q    <= '0;
      half_to_take_q <= 1'b0;
    end else begin
      case (state_q)
        SQ_TAKE: if (seg_valid) begin
          if (seg_end) begin
            if (cnt_q == '0) begin
              err_q   <= PRD_ERR_EMPTY;
              state_q <= SQ_FIN;
            end else begin
              state_q <= SQ_SEAL;
            end
          end else if (misalign) begin
            err_q   <= PRD_ERR_ALIGN;
            state_q <= SQ_DRAIN;
          end else begin
            cur_addr_q <= seg_addr;
            remain_q   <= seg_len;
            state_q    <= SQ_CHOP;
          end
        end
        SQ_CHOP: begin
          if (over) begin
            err_q   <= PRD_ERR_FULL;
            state_q <= SQ_DRAIN;
          end else if (push_ready) begin
            cnt_q      <= cnt_q + CNT_W'(need_w);
            cur_addr_q <= cur_addr_q + {15'd0, chunk};
            remain_q   <= remain_q - LEN_W'(chunk);
            if (split) begin
              half_base_q    <= cur_addr_q + HALF_OFFSET;
              half_to_take_q <= last_piece;
              state_q        <= SQ_HALF;
            end else if (last_piece) begin
              state_q <= SQ_TAKE;
            end
          end
        end
        SQ_HALF: if (push_ready) state_q <= half_to_take_q ? SQ_TAKE : SQ_CHOP;
        SQ_SEAL: if (seal_ready) state_q <= SQ_WAIT;
        SQ_WAIT: if (stage_idle) state_q <= SQ_FIN;
        SQ_DRAIN: if (seg_valid && seg_end) state_q <= SQ_WAIT;
        SQ_FIN: begin
          cnt_q   <= '0;
          err_q   <= PRD_OK;
          state_q <= SQ_TAKE;
        end
        default: state_q <= SQ_TAKE;
      endcase
    end
  end

endmodule

// File: rtl/prdgen_top.sv
module prdgen_top #(
  parameter  int MAX_ENTRIES = 256,
  parameter  int LEN_W       = 20,
  localparam int CNT_W       = $clog2(MAX_ENTRIES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_split_64k,
  input  logic             cfg_wide_count,
  input  logic             seg_valid,
  output logic             seg_ready,
  input  logic [31:0]      seg_addr,
  input  logic [LEN_W-1:0] seg_len,
  output logic             wr_valid,
  input  logic             wr_ready,
  output logic [31:0]      wr_data,
  output logic             wr_last,
  output logic             done,
  output logic [1:0]       err_code,
  output logic [CNT_W-1:0] entry_count
);
  import prdgen_pkg::*;

  logic       push_valid;
  prd_entry_t push_entry;
  logic       push_ready;
  logic       seal_valid;
  logic       seal_ready;
  logic       discard;
  logic       stage_idle;

  prdgen_seq #(
    .MAX_ENTRIES (MAX_ENTRIES),
    .LEN_W       (LEN_W),
    .CNT_W       (CNT_W)
  ) u_seq (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_split_64k  (cfg_split_64k),
    .cfg_wide_count (cfg_wide_count),
    .seg_valid      (seg_valid),
    .seg_ready      (seg_ready),
    .seg_addr       (seg_addr),
    .seg_len        (seg_len),
    .push_valid     (push_valid),
    .push_entry     (push_entry),
    .push_ready     (push_ready),
    .seal_valid     (seal_valid),
    .seal_ready     (seal_ready),
    .discard        (discard),
    .stage_idle     (stage_idle),
    .done           (done),
    .err_code       (err_code),
    .entry_count    (entry_count)
  );

  prdgen_stage u_stage (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_valid (push_valid),
    .push_entry (push_entry),
    .push_ready (push_ready),
    .seal_valid (seal_valid),
    .seal_ready (seal_ready),
    .discard    (discard),
    .idle       (stage_idle),
    .wr_valid   (wr_valid),
    .wr_ready   (wr_ready),
    .wr_data    (wr_data),
    .wr_last    (wr_last)
  );

endmodule

// File: rtl/prdgen_checker.sv
module prdgen_checker #(
  parameter int MAX_ENTRIES = 256,
  parameter int CNT_W       = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_split_64k,
  input logic             cfg_wide_count,
  input logic             wr_valid,
  input logic             wr_ready,
  input logic [31:0]      wr_data,
  input logic             wr_last,
  input logic             done,
  input logic [1:0]       err_code,
  input logic [CNT_W-1:0] entry_count
);
  logic        ph;
  logic [15:0] base_lo;
  logic [17:0] span;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph      <= 1'b0;
      base_lo <= '0;
    end else if (wr_valid && wr_ready) begin
      ph <= ~ph;
      if (!ph) base_lo <= wr_data[15:0];
    end
  end

  always_comb
    span = {2'b00, base_lo} +
           ((wr_data[15:0] == 16'h0) ? 18'h1_0000 : {2'b00, wr_data[15:0]});

  p_no_cross_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && ph && !cfg_wide_count) |-> (span <= 18'h1_0000));

  p_default_hi_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && ph && !cfg_wide_count) |-> (wr_data[30:16] == 15'd0));

  p_no_zero_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && ph && cfg_split_64k && !cfg_wide_count) |-> (wr_data[15:0] != 16'h0));

  p_wide_fields_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && ph && cfg_wide_count) |-> (wr_data[15:0] == 16'h0 && !wr_data[30]));

  p_count_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (int'(entry_count) <= MAX_ENTRIES));

  p_end_mark_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && ph) |-> (wr_data[31] == wr_last));

  p_last_on_ctrl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_last |-> ph);

  p_empty_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err_code == 2'd2) |-> (entry_count == '0));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!wr_valid && !ph));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_data) && $stable(wr_last)));

endmodule

bind prdgen_top prdgen_checker #(
  .MAX_ENTRIES (MAX_ENTRIES),
  .CNT_W       (CNT_W)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .cfg_split_64k  (cfg_split_64k),
  .cfg_wide_count (cfg_wide_count),
  .wr_valid       (wr_valid),
  .wr_ready       (wr_ready),
  .wr_data        (wr_data),
  .wr_last        (wr_last),
  .done           (done),
  .err_code       (err_code),
  .entry_count    (entry_count)
);

// File: tb/sim_prdgen_top.sv
`timescale 1ns/1ps
module sim_prdgen_top;
  localparam int MAXE  = 8;
  localparam int LEN_W = 20;
  localparam int CNT_W = $clog2(MAXE + 1);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cfg_split_64k = 1'b0;
  logic             cfg_wide_count = 1'b0;
  logic             seg_valid = 1'b0;
  logic             seg_ready;
  logic [31:0]      seg_addr = '0;
  logic [LEN_W-1:0] seg_len = '0;
  logic             wr_valid;
  logic             wr_ready = 1'b0;
  logic [31:0]      wr_data;
  logic             wr_last;
  logic             done;
  logic [1:0]       err_code;
  logic [CNT_W-1:0] entry_count;

  prdgen_top #(.MAX_ENTRIES(MAXE), .LEN_W(LEN_W)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_split_64k(cfg_split_64k),
    .cfg_wide_count(cfg_wide_count), .seg_valid(seg_valid),
    .seg_ready(seg_ready), .seg_addr(seg_addr), .seg_len(seg_len),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .wr_last(wr_last), .done(done), .err_code(err_code),
    .entry_count(entry_count)
  );

  always #5 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit bp_on = 1'b0;

  logic [31:0] got_w[$];
  logic        got_l[$];
  logic [31:0] exp_w[$];
  int          exp_err;
  int          exp_cnt;
  logic [31:0] sa[$];
  logic [31:0] sl[$];

  always @(negedge clk)
    if (wr_valid && wr_ready) begin
      got_w.push_back(wr_data);
      got_l.push_back(wr_last);
    end

  always @(posedge clk) begin
    #1;
    wr_ready = bp_on ? (($urandom % 3) != 0) : 1'b1;
  end

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic build_expect(bit sp, bit wd);
    int cnt = 0;
    int err = 0;
    exp_w.delete();
    for (int i = 0; i < sa.size(); i++) begin
      logic [31:0] a = sa[i];
      logic [31:0] r = sl[i];
      bit bad = wd ? (((a | r) & 32'd3) != 0) : (((a | r) & 32'd1) != 0);
      if (bad) begin err = 3; break; end
      while (r != 0) begin
        logic [31:0] room = 32'h1_0000 - (a & 32'hFFFF);
        logic [31:0] c = (r < room) ? r : room;
        bit spl = sp && !wd && (c == 32'h1_0000);
        int need = spl ? 2 : 1;
        if (cnt + need > MAXE) begin err = 1; break; end
        if (spl) begin
          exp_w.push_back(a); exp_w.push_back(32'h8000);
          exp_w.push_back(a + 32'h8000); exp_w.push_back(32'h8000);
        end else begin
          exp_w.push_back(a);
          exp_w.push_back(wd ? (((c >> 2) - 1) << 16) : (c & 32'hFFFF));
        end
        cnt += need; a += c; r -= c;
      end
      if (err != 0) break;
    end
    if (err == 0) begin
      if (cnt == 0) err = 2;
      else exp_w[exp_w.size()-1] = exp_w[exp_w.size()-1] | 32'h8000_0000;
    end else if (exp_w.size() >= 2) begin
      void'(exp_w.pop_back());
      void'(exp_w.pop_back());
    end
    exp_err = err;
    exp_cnt = cnt;
  endtask

  task automatic send_seg(logic [31:0] a, logic [31:0] l);
    @(posedge clk); #1;
    seg_valid = 1'b1; seg_addr = a; seg_len = LEN_W'(l);
    @(negedge clk);
    while (!seg_ready) @(negedge clk);
    @(posedge clk); #1;
    seg_valid = 1'b0;
  endtask

  task automatic run_table(string name, bit sp, bit wd, string req);
    int bad_i = -1;
    logic [1:0] e_got;
    logic [CNT_W-1:0] c_got;
    cfg_split_64k = sp; cfg_wide_count = wd;
    build_expect(sp, wd);
    got_w.delete(); got_l.delete();
    foreach (sa[i]) send_seg(sa[i], sl[i]);
    send_seg(32'h0, 32'h0);
    @(negedge clk);
    while (!done) @(negedge clk);
    e_got = err_code; c_got = entry_count;
    repeat (3) @(negedge clk);
    if (got_w.size() == exp_w.size()) begin
      for (int i = 0; i < got_w.size(); i++) begin
        bit lx = (exp_err == 0) && (i == got_w.size() - 1);
        if (got_w[i] !== exp_w[i] || got_l[i] !== lx) begin bad_i = i; break; end
      end
    end
    if (got_w.size() != exp_w.size())
      check(1'b0, req, {name, " word count"}, 64'(got_w.size()), 64'(exp_w.size()));
    else if (bad_i >= 0)
      check(1'b0, req, {name, " word/last"}, {31'd0, got_l[bad_i], got_w[bad_i]}, 64'(exp_w[bad_i]));
    else
      check(1'b1, req, name, 0, 0);
    check(e_got == 2'(exp_err), req, {name, " err_code"}, 64'(e_got), 64'(exp_err));
    check(int'(c_got) == exp_cnt, "R9", {name, " entry_count"}, 64'(c_got), 64'(exp_cnt));
    sa.delete(); sl.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R9 watchdog expired: actual 0 expected 1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(wr_valid == 1'b0, "R12", "reset wr_valid", 64'(wr_valid), 0);
    check(done == 1'b0, "R12", "reset done", 64'(done), 0);
    check(seg_ready == 1'b1, "R12", "reset seg_ready", 64'(seg_ready), 1);
    @(posedge clk); #1 rst_n = 1'b1;

    // R2 small piece, default encoding
    sa.push_back(32'h0000_1000); sl.push_back(32'h200);
    run_table("small", 0, 0, "R2 R7");
    // R1 crossing a 64 KB boundary
    sa.push_back(32'h0001_F000); sl.push_back(32'h3000);
    run_table("cross", 0, 0, "R1");
    // R2 full 64 KB piece encodes as zero count
    sa.push_back(32'h0002_0000); sl.push_back(32'h1_0000);
    run_table("full64k", 0, 0, "R2");
    // R3 full piece split into halves
    sa.push_back(32'h0002_0000); sl.push_back(32'h1_0000);
    run_table("split", 1, 0, "R3");
    // R4 wide encoding, split ignored
    sa.push_back(32'h0003_0000); sl.push_back(32'h1_0000);
    sa.push_back(32'h0000_0010); sl.push_back(32'h8);
    run_table("wide", 1, 1, "R4");
    // R5 odd address after a good segment
    sa.push_back(32'h0000_2000); sl.push_back(32'h100);
    sa.push_back(32'h0000_1001); sl.push_back(32'h10);
    run_table("odd_addr", 0, 0, "R5 R13");
    // R5 wide encoding with a length not a multiple of 4
    sa.push_back(32'h0000_4000); sl.push_back(32'h6);
    run_table("wide_len", 0, 1, "R5");
    // R6 overflow from one long segment
    sa.push_back(32'h0000_0000); sl.push_back(32'h9_0000);
    run_table("overflow", 0, 0, "R6 R13");
    // R6 exactly full table succeeds
    sa.push_back(32'h0000_0000); sl.push_back(32'h8_0000);
    run_table("exact_full", 0, 0, "R6");
    // R6 split piece needing two slots with one left
    for (int i = 0; i < 7; i++) begin
      sa.push_back(32'h0000_F000 + 32'(i) * 32'h1_0000); sl.push_back(32'h1000);
    end
    sa.push_back(32'h0010_0000); sl.push_back(32'h1_0000);
    run_table("split_last_slot", 1, 0, "R6 R3 R13");
    // R8 empty list
    run_table("empty", 0, 0, "R8");

    // R10 R11 random tables with back-pressure
    bp_on = 1'b1;
    for (int t = 0; t < 40; t++) begin
      bit wd = ($urandom % 3) == 0;
      bit sp = ($urandom % 2) == 0;
      int ns = 1 + ($urandom % 4);
      logic [31:0] mask = wd ? 32'd3 : 32'd1;
      for (int s = 0; s < ns; s++) begin
        logic [31:0] a = $urandom & ~mask;
        logic [31:0] l;
        case ($urandom % 3)
          0: l = 1 + ($urandom % 32'h3000);
          1: begin a = a & 32'hFFFF_0000; l = 32'h1_0000; end
          default: l = 1 + ($urandom % 32'h4_0000);
        endcase
        l = l & ~mask;
        if (l == 0) l = mask + 1;
        if (($urandom % 10) == 0) a = a | 32'd1;
        sa.push_back(a); sl.push_back(l);
      end
      run_table("random", sp, wd, "R10 R11");
    end
    bp_on = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule